// File: doc/BRIEF.md
# SIMD Lane Shift-Right-Immediate Unit

This unit takes one 32-bit vector instruction word and a 128-bit source vector. It decodes the word and shifts every lane of the vector right by an immediate count. The lanes are 8, 16 or 32 bits wide. Lanes can be signed or unsigned, and each can be shifted with truncation or with round-to-nearest. The decoded lane size, the shift count and an illegal-encoding flag are returned next to the result.

One 6-bit immediate field carries both the lane size and the shift count. A leading-one marker at the top of the field gives the lane size. The bits below the marker hold the lane width minus the count. Inside the unit, each right shift is performed as a shift by the negated count, so one lane shifter serves both directions. The result appears on the clock edge that samples the valid strobe. An illegal word leaves the result register unchanged.

Top module: `lane_shr_imm`

## Requirements
- R1: Lane size comes from insn_i[21:16]. If bit 21 is 1, lanes are 32 bits and size_o is 2. If bits 21:20 are 01, lanes are 16 bits and size_o is 1. If bits 21:19 are 001, lanes are 8 bits and size_o is 0.
- R2: E is the field below the marker: insn_i[20:16] for 32-bit lanes, insn_i[19:16] for 16-bit lanes and insn_i[18:16] for 8-bit lanes. The shift count S is the lane width minus E, and shamt_o reports S (1 to the lane width).
- R3: insn_i[28]=1 selects unsigned lanes. With variant field insn_i[11:8]=0000, an unsigned lane is shifted right by S with zero fill.
- R4: insn_i[28]=0 selects signed lanes. With variant 0000, a signed lane is shifted right arithmetically by S, filling with the sign bit.
- R5: Variant insn_i[11:8]=0010 rounds. The unit adds 2^(S-1) to the sign- or zero-extended lane value, with no loss of carry, and then shifts right by S.
- R6: When S equals the lane width, the results are as follows. Truncating unsigned gives 0. Truncating signed gives all sign bits. Rounding signed gives 0. Rounding unsigned gives 1 if the lane's top bit is set, and 0 otherwise.
- R7: Every lane is computed independently with the same count. The vector holds 16, 8 or 4 lanes; lane k occupies bits [k*W +: W].
- R8: A word is illegal if bits 21:19 are 000, or if any of these fixed fields mismatch: [27:23]=11111, [12]=0, [7:6]=01, [4]=1, [0]=0, [11:8] in {0000,0010}. For an illegal word with valid_i high, illegal_o becomes 1, and result_o, size_o and shamt_o keep their values.
- R9: All outputs update on the clock edge that samples valid_i=1. While valid_i is 0, all outputs hold.
- R10: While rst_ni is low, result_o, size_o, shamt_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and vector are present this cycle |
| insn_i | input | 32 | Instruction word |
| vec_i | input | 128 | Source vector |
| result_o | output | 128 | Registered shifted vector |
| size_o | output | 2 | Lane size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| shamt_o | output | 6 | Decoded right-shift count |
| illegal_o | output | 1 | The last sampled word was illegal |

## Verification
The bench sweeps all four variants over all three lane sizes. The counts include 1, mid-range values, W-1 and W, and the vectors carry lanes with the top bit set and clear. A design that shifts by E instead of W-E, or that decodes the size marker wrongly, gives wrong counts and garbled lanes. A design that drops the rounding carry gives 0 instead of 1 for unsigned lanes at full-width shifts, and one that fills signed lanes with zeros loses negative values. Illegal words with a bad size marker, a stray fixed bit or an unknown variant must raise the flag without touching the held result. Idle cycles must change nothing.

// File: rtl/lane_shr_pkg.sv
package lane_shr_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned NSZ    = 3;
  localparam int unsigned CNT_W  = 6;

  typedef enum logic [1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2
  } lane_sz_e;

  typedef struct packed {
    lane_sz_e         size;
    logic [CNT_W-1:0] shamt;
    logic             sgn;
    logic             rnd;
    logic             illegal;
  } dec_t;
endpackage

// File: rtl/lane_shr_decode.sv
module lane_shr_decode
  import lane_shr_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  logic [5:0] imm;
  logic       bad_sz;
  logic       fixed_ok;
  logic       op_ok;
  logic       unused_bits;

  assign imm         = insn_i[21:16];
  assign unused_bits = ^{insn_i[31:29], insn_i[22], insn_i[15:13], insn_i[5], insn_i[3:1]};

  always_comb begin
    bad_sz         = 1'b0;
    dec_o.size     = LSZ_8;
    dec_o.shamt    = '0;
    // leading-one marker picks the lane size; remaining bits hold width - count
    if (imm[5]) begin
      dec_o.size  = LSZ_32;
      dec_o.shamt = 6'd32 - {1'b0, imm[4:0]};
    end else if (imm[4]) begin
      dec_o.size  = LSZ_16;
      dec_o.shamt = 6'd16 - {2'b0, imm[3:0]};
    end else if (imm[3]) begin
      dec_o.size  = LSZ_8;
      dec_o.shamt = 6'd8 - {3'b0, imm[2:0]};
    end else begin
      bad_sz = 1'b1;
    end
  end

  assign fixed_ok = (insn_i[27:23] == 5'b11111) && !insn_i[12] &&
                    (insn_i[7:6] == 2'b01) && insn_i[4] && !insn_i[0];
  assign op_ok    = (insn_i[11:8] == 4'b0000) || (insn_i[11:8] == 4'b0010);

  assign dec_o.sgn     = !insn_i[28];
  assign dec_o.rnd     = insn_i[9];
  assign dec_o.illegal = bad_sz || !fixed_ok || !op_ok;
endmodule

// File: rtl/lane_shr_lane.sv
// Bidirectional lane shifter: negative amount shifts right, optionally rounding.
module lane_shr_lane #(
  parameter int unsigned W  = 8,
  localparam int unsigned AW = $clog2(W) + 2,
  localparam int unsigned XW = W + 2
) (
  input  logic [W-1:0]         x_i,
  input  logic signed [AW-1:0] amt_i,
  input  logic                 sgn_i,
  input  logic                 rnd_i,
  output logic [W-1:0]         y_o
);
  logic                 right;
  logic [AW-1:0]        mag;
  logic signed [XW-1:0] wide;
  logic signed [XW-1:0] bias;
  logic signed [XW-1:0] sum;
  logic signed [XW-1:0] shr;
  logic [XW-1:0]        shl;

  always_comb begin
    right = amt_i[AW-1];
    mag   = right ? AW'(-amt_i) : AW'(amt_i);
    wide  = sgn_i ? {{2{x_i[W-1]}}, x_i} : {2'b00, x_i};
    bias  = '0;
    if (right && rnd_i && (mag != '0))
      bias = XW'(1) <<< (mag - AW'(1));
    sum = wide + bias;
    shr = sum >>> mag;
    shl = wide << mag;
    y_o = right ? shr[W-1:0] : shl[W-1:0];
  end
endmodule

// File: rtl/lane_shr_array.sv
module lane_shr_array
  import lane_shr_pkg::*;
(
  input  logic [VEC_W-1:0] vec_i,
  input  dec_t             dec_i,
  output logic [VEC_W-1:0] vec_o
);
  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int unsigned W  = 8 << g;
    localparam int unsigned N  = VEC_W / W;
    localparam int unsigned AW = $clog2(W) + 2;

    logic [VEC_W-1:0]     r;
    logic signed [AW-1:0] amt;
    logic signed [CNT_W:0] neg;

    // right shift is issued as a left shift by the negated count
    assign neg = -$signed({1'b0, dec_i.shamt});
    assign amt = neg[AW-1:0];

    for (genvar k = 0; k < N; k++) begin : g_lane
      lane_shr_lane #(.W(W)) u_lane (
        .x_i   (vec_i[k*W +: W]),
        .amt_i (amt),
        .sgn_i (dec_i.sgn),
        .rnd_i (dec_i.rnd),
        .y_o   (r[k*W +: W])
      );
    end
  end

  always_comb begin
    unique case (dec_i.size)
      LSZ_16:  vec_o = g_sz[1].r;
      LSZ_32:  vec_o = g_sz[2].r;
      default: vec_o = g_sz[0].r;
    endcase
  end
endmodule

// File: rtl/lane_shr_imm.sv
module lane_shr_imm
  import lane_shr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [VEC_W-1:0]  result_o,
  output logic [1:0]        size_o,
  output logic [CNT_W-1:0]  shamt_o,
  output logic              illegal_o
);
  dec_t             dec;
  logic [VEC_W-1:0] res_d;

  lane_shr_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  lane_shr_array u_arr (
    .vec_i (vec_i),
    .dec_i (dec),
    .vec_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      size_o    <= '0;
      shamt_o   <= '0;
      illegal_o <= 1'b0;
    end else if (valid_i) begin
      illegal_o <= dec.illegal;
      if (!dec.illegal) begin
        result_o <= res_d;
        size_o   <= dec.size;
        shamt_o  <= dec.shamt;
      end
    end
  end
endmodule

// File: rtl/lane_shr_imm_chk.sv
module lane_shr_imm_chk
  import lane_shr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [VEC_W-1:0] result_o,
  input logic [1:0]       size_o,
  input logic [CNT_W-1:0] shamt_o,
  input logic             illegal_o
);
  p_size_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_o != 2'b11);

  p_shamt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (illegal_o ||
      (shamt_o >= 6'd1 &&
       ((size_o == 2'd0 && shamt_o <= 6'd8) ||
        (size_o == 2'd1 && shamt_o <= 6'd16) ||
        (size_o == 2'd2 && shamt_o <= 6'd32)))));

  p_illegal_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (!illegal_o || ($stable(result_o) && $stable(size_o) && $stable(shamt_o))));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o) && $stable(shamt_o)));
endmodule

bind lane_shr_imm lane_shr_imm_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .result_o  (result_o),
  .size_o    (size_o),
  .shamt_o   (shamt_o),
  .illegal_o (illegal_o)
);

// File: tb/lane_shr_imm_tb.sv
module lane_shr_imm_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  insn_i = '0;
  logic [127:0] vec_i = '0;
  logic [127:0] result_o;
  logic [1:0]   size_o;
  logic [5:0]   shamt_o;
  logic         illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lane_shr_imm u_dut (.*);

  function automatic logic [31:0] mk(bit u, bit rnd, logic [5:0] imm);
    logic [31:0] w = '0;
    w[31:29] = 3'b111; w[28] = u; w[27:23] = 5'b11111;
    w[21:16] = imm; w[12] = 1'b0; w[11:8] = rnd ? 4'b0010 : 4'b0000;
    w[7:6] = 2'b01; w[4] = 1'b1; w[0] = 1'b0;
    return w;
  endfunction

  function automatic logic [5:0] imm_for(int w, int s);
    if (w == 32) return {1'b1, 5'(32 - s)};
    if (w == 16) return {2'b01, 4'(16 - s)};
    return {3'b001, 3'(8 - s)};
  endfunction

  function automatic logic [127:0] model(bit u, bit rnd, int w, int s, logic [127:0] v);
    logic [127:0] r = '0;
    longint mask = (longint'(1) << w) - 1;
    for (int k = 0; k < 128 / w; k++) begin
      longint x = longint'((v >> (k * w)) & 128'(mask));
      if (!u && x[w-1]) x = x - (longint'(1) << w);
      if (rnd) x = x + (longint'(1) << (s - 1));
      x = x >>> s;
      r = r | (128'(x & mask) << (k * w));
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic [127:0] v);
    @(negedge clk_i);
    valid_i = 1'b1; insn_i = w; vec_i = v;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 result", result_o, '0);
    chk("R10 flags", {illegal_o, size_o, shamt_o}, '0);
  endtask

  task automatic t_sweep(logic [127:0] v);
    int shs[5];
    for (int g = 0; g < 3; g++) begin
      int w = 8 << g;
      shs = '{1, 3, w / 2, w - 1, w};
      for (int var_i = 0; var_i < 4; var_i++) begin
        bit u = var_i[0];
        bit rnd = var_i[1];
        for (int j = 0; j < 5; j++) begin
          issue(mk(u, rnd, imm_for(w, shs[j])), v);
          // R3 R4 R5 R7 lane results
          chk(rnd ? "R5 round" : (u ? "R3 unsigned" : "R4 signed"),
              result_o, model(u, rnd, w, shs[j], v));
          chk("R1 size", 128'(size_o), 128'(g));
          chk("R2 shamt", 128'(shamt_o), 128'(shs[j]));
          chk("R8 legal flag", 128'(illegal_o), '0);
        end
      end
    end
  endtask

  task automatic t_full_width();
    logic [127:0] v = {32'h8000_0001, 32'h7FFF_FFFF, 32'hC000_0000, 32'h0000_0000};
    issue(mk(1'b1, 1'b1, imm_for(32, 32)), v);
    chk("R6 round unsigned W", result_o, {32'd1, 32'd0, 32'd1, 32'd0});
    issue(mk(1'b0, 1'b1, imm_for(32, 32)), v);
    chk("R6 round signed W", result_o, '0);
    issue(mk(1'b0, 1'b0, imm_for(32, 32)), v);
    chk("R6 trunc signed W", result_o, {32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 32'd0});
    issue(mk(1'b1, 1'b0, imm_for(8, 8)), {16{8'hFF}});
    chk("R6 trunc unsigned W", result_o, '0);
    issue(mk(1'b1, 1'b1, imm_for(8, 8)), {8{8'h80, 8'h7F}});
    chk("R6 round unsigned 8", result_o, {8{8'h01, 8'h00}});
  endtask

  task automatic t_lanes();
    logic [127:0] v = '0;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'(k * 17);
    issue(mk(1'b1, 1'b0, imm_for(8, 4)), v);
    chk("R7 lanes", result_o, model(1'b1, 1'b0, 8, 4, v));
    issue(mk(1'b0, 1'b1, imm_for(16, 5)), v);
    chk("R7 lanes 16", result_o, model(1'b0, 1'b1, 16, 5, v));
  endtask

  task automatic t_illegal();
    logic [127:0] held;
    logic [31:0] w;
    issue(mk(1'b1, 1'b0, imm_for(16, 2)), {8{16'hA5C3}});
    held = result_o;
    issue(mk(1'b1, 1'b0, 6'b000101), {8{16'h1234}});
    chk("R8 bad marker flag", 128'(illegal_o), 128'(1));
    chk("R8 bad marker hold", result_o, held);
    chk("R8 hold shamt", 128'(shamt_o), 128'(2));
    w = mk(1'b0, 1'b0, imm_for(8, 1)); w[12] = 1'b1;
    issue(w, '1);
    chk("R8 bit12 flag", 128'(illegal_o), 128'(1));
    chk("R8 bit12 hold", result_o, held);
    w = mk(1'b0, 1'b0, imm_for(8, 1)); w[11:8] = 4'b0001;
    issue(w, '1);
    chk("R8 variant flag", 128'(illegal_o), 128'(1));
    chk("R8 variant hold", result_o, held);
    w = mk(1'b0, 1'b0, imm_for(8, 1)); w[7:6] = 2'b11;
    issue(w, '1);
    chk("R8 bits7_6 flag", 128'(illegal_o), 128'(1));
    issue(mk(1'b0, 1'b0, imm_for(8, 1)), '1);
    chk("R8 clear", 128'(illegal_o), '0);
    chk("R8 after", result_o, '1);
  endtask

  task automatic t_idle();
    logic [127:0] held = result_o;
    @(negedge clk_i);
    insn_i = mk(1'b1, 1'b0, imm_for(32, 7)); vec_i = 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
    repeat (3) @(negedge clk_i);
    chk("R9 idle hold", result_o, held);
    chk("R9 idle flag", 128'(illegal_o), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_sweep({8'h80, 8'hFF, 8'h7F, 8'h01, 8'h00, 8'hC3, 8'h55, 8'hAA,
             8'h81, 8'hFE, 8'h40, 8'h3F, 8'h92, 8'h6D, 8'hE7, 8'h18});
    t_sweep(128'hFEDC_BA98_7654_3210_8000_7FFF_0001_FFFF);
    t_full_width();
    t_lanes();
    t_illegal();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule